// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is a two-wire bus (I2C) slave that gives a master read access to a small byte-wide memory. It looks at each 8-bit slave header and compares it with a fixed device pattern plus two strap pins. It acknowledges only a header that matches. A write header carries a two-byte word address into an internal address pointer. A read header streams bytes out from that pointer and advances it after each byte.

The master can reach the data in four ways:
- A current-address read sends only a read header.
- A random read sends the word address, then a repeated start and a read header.
- A sequential read acknowledges each data byte to get the next one.
- A set-address transaction sends the word address and then a stop, which only moves the pointer.

SCL and SDA are open-drain lines. The block sees them as plain inputs and pulls SDA low through an output-enable. Both lines are resynchronised to the core clock. The memory contents are a fixed computed pattern and are loaded at reset.

Top module: `i2c_mem_rd_slave`

## Requirements
- R1: A header byte arrives MSB first and is acknowledged only when its upper seven bits equal `1010`, then `0`, then `sel_i[1]`, then `sel_i[0]`. Its LSB selects the direction: 1 is a read and 0 is a write. Any other header gets no acknowledge.
- R2: After an acknowledged write header, the next two bytes form the word address, high byte first. The slave acknowledges each of them. Only the low AW bits of the 16-bit value are kept.
- R3: A write header and word address followed by a stop move no data and leave the pointer at the supplied address.
- R4: A read header right after a start returns the byte at the pointer. This includes a pointer set by R3 or left by an earlier read.
- R5: A write header and word address, then a repeated start and a read header, return the byte at the supplied address.
- R6: A master acknowledge (SDA low on the ninth clock) after a data byte makes the slave send the byte at the next address. A master no-acknowledge ends the read, and SDA is released.
- R7: Sequential reading past address 2^AW-1 continues at address 0.
- R8: After a stop, a mismatched header or a read that ended in a no-acknowledge, the slave ignores all bus traffic until the next start. Any start or stop releases SDA.
- R9: Bytes that follow the word address in a write are not acknowledged and do not change the pointer.
- R10: SDA is driven only while SCL is low. Its value holds for the whole time SCL is high. After reset SDA is released.
- R11: The byte stored at address a is (37·a + 11) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sel_i | input | 2 | Strap pins for the device select bits |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |

## Verification
A change on SCL passes through two synchroniser stages and one edge register. The acknowledge or data bit from the slave therefore appears on `sda_oe_o` three to four core cycles after SCL falls. No slave response is due during SCL high time. The bench holds every SCL half period for 16 cycles. Its reference model holds the expected slave drive for each bit and compares it with `sda_oe_o` on every clock in the second half of each SCL high phase, so a correct design is never sampled while its reply is still on the way. The reference address pointer is treated as unknown until the bench loads it, and read data is predicted only from that model pointer and the R11 formula.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_HOLD,
    ST_RD,
    ST_RD_ACK
  } rd_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  function automatic logic [7:0] mem_seed(input int unsigned a);
    return 8'((a * 37 + 11) & 255);
  endfunction

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  // bus idles high, so reset to ones to avoid a fake edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_o;
      sda_q    <= sda_o;
    end
  end

  assign scl_o      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem
  import i2c_rd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    data_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] words_q [DEPTH];

  // contents are fixed at reset; array programming is not part of this block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) words_q[i] <= mem_seed(i);
    end
  end

  assign data_o = words_q[addr_i];

endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          sda_oe_o
);

  rd_state_e     state_q;
  logic [2:0]    bit_cnt_q;
  logic [7:0]    shreg_q;
  logic          rw_q, phase_q, mack_q, oe_q;
  logic [AW-1:0] ptr_q, ld_addr;
  logic [7:0]    byte_in;
  logic          byte_done, hdr_ok, bus_evt, ptr_inc, ptr_ld;

  always_comb begin
    byte_in   = {shreg_q[6:0], sda_s_i};
    byte_done = scl_rise_i && (bit_cnt_q == 3'd7);
    hdr_ok    = byte_in[7:1] == {DEV_TYPE, 1'b0, sel_i};
    bus_evt   = start_i || stop_i;
    ptr_inc   = !bus_evt && scl_fall_i && phase_q &&
                ((state_q == ST_DEV_ACK && rw_q) || (state_q == ST_RD_ACK && mack_q));
    ptr_ld    = !bus_evt && state_q == ST_ALO && byte_done;
  end

  if (AW > 8) begin : g_hi
    logic [AW-9:0] hi_q;
    always_ff @(posedge clk_i) begin
      if (!bus_evt && state_q == ST_AHI && byte_done) hi_q <= byte_in[AW-9:0];
    end
    assign ld_addr = {hi_q, byte_in};
  end else begin : g_lo
    assign ld_addr = byte_in[AW-1:0];
  end

  // pointer is left unreset: its power-up value carries no meaning
  always_ff @(posedge clk_i) begin
    if (ptr_ld)       ptr_q <= ld_addr;
    else if (ptr_inc) ptr_q <= ptr_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      rw_q      <= 1'b0;
      phase_q   <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      phase_q   <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_AHI, ST_ALO: begin
          if (scl_rise_i) begin
            shreg_q   <= byte_in;
            bit_cnt_q <= bit_cnt_q + 3'd1;
          end
          if (byte_done) begin
            if (state_q == ST_DEV) begin
              rw_q    <= byte_in[0];
              state_q <= hdr_ok ? ST_DEV_ACK : ST_IDLE;
            end else if (state_q == ST_AHI) begin
              state_q <= ST_AHI_ACK;
            end else begin
              state_q <= ST_ALO_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK: begin
          if (scl_fall_i) begin
            if (!phase_q) begin
              phase_q <= 1'b1;
              oe_q    <= 1'b1;
            end else begin
              phase_q   <= 1'b0;
              bit_cnt_q <= '0;
              oe_q      <= 1'b0;
              if (state_q == ST_DEV_ACK && rw_q) begin
                state_q <= ST_RD;
                shreg_q <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
              end else if (state_q == ST_DEV_ACK) begin
                state_q <= ST_AHI;
              end else if (state_q == ST_AHI_ACK) begin
                state_q <= ST_ALO;
              end else begin
                state_q <= ST_HOLD;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) phase_q <= 1'b1;
          end
          if (scl_fall_i) begin
            if (phase_q) begin
              oe_q    <= 1'b0;
              phase_q <= 1'b0;
              state_q <= ST_RD_ACK;
            end else begin
              shreg_q <= {shreg_q[6:0], 1'b0};
              oe_q    <= ~shreg_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            mack_q  <= ~sda_s_i;
            phase_q <= 1'b1;
          end
          if (scl_fall_i && phase_q) begin
            phase_q <= 1'b0;
            if (mack_q) begin
              state_q   <= ST_RD;
              bit_cnt_q <= '0;
              shreg_q   <= rd_data_i;
              oe_q      <= ~rd_data_i[7];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign addr_o   = ptr_q;
  assign sda_oe_o = oe_q;

endmodule

// File: rtl/i2c_mem_rd_slave.sv
module i2c_mem_rd_slave #(
  parameter int unsigned AW          = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] sel_i,
  output logic       sda_oe_o
);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_rd_mem #(.AW(AW)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (rd_addr),
    .data_o (rd_data)
  );

  i2c_rd_fsm #(.AW(AW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rd_data_i  (rd_data),
    .addr_o     (rd_addr),
    .sda_oe_o   (sda_oe_o)
  );

endmodule

// File: rtl/i2c_rd_slave_chk.sv
module i2c_rd_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s_i,
  input logic sda_oe_i,
  input logic start_i,
  input logic stop_i
);

  // R10
  oe_hold_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i)) |-> $stable(sda_oe_i));

  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_s_i);

  // R8
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  // R8
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

endmodule

bind i2c_mem_rd_slave i2c_rd_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s_i  (scl_s),
  .sda_oe_i (sda_oe_o),
  .start_i  (start_det),
  .stop_i   (stop_det)
);

// File: tb/i2c_mem_rd_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_rd_slave_tb_top;

  localparam int AW = 5;
  localparam int Q  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic [1:0] sel = 2'b10;
  logic       sda_oe;
  logic       sda_line;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit    cmp_en = 0;
  logic  cur_exp = 1'b0;
  string cur_tag = "";
  int    model_ptr = -1;

  always #5 clk = ~clk;

  assign sda_line = !(m_low || sda_oe);

  i2c_mem_rd_slave #(.AW(AW)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sel_i    (sel),
    .sda_oe_o (sda_oe)
  );

  function automatic logic [7:0] mem_val(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  // per-clock comparison against the modelled slave drive
  always @(negedge clk) begin
    if (cmp_en) begin
      n_chk++;
      if (sda_oe !== cur_exp) begin
        n_fail++;
        $display("FAIL %s: sda_oe_o=%b expected %b at %0t", cur_tag, sda_oe, cur_exp, $time);
      end
    end
  end

  task automatic wait_q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic clock_bit(input logic drv, input logic exp, input string tag);
    wait_q();
    m_low = drv;
    wait_q();
    scl = 1'b1;
    cur_exp = exp;
    cur_tag = tag;
    wait_q();
    cmp_en = 1'b1;
    wait_q();
    cmp_en = 1'b0;
    scl = 1'b0;
  endtask

  task automatic bus_start();
    wait_q(); m_low = 1'b0;
    wait_q(); scl = 1'b1;
    wait_q(); m_low = 1'b1;
    wait_q(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_q(); m_low = 1'b1;
    wait_q(); scl = 1'b1;
    wait_q(); m_low = 1'b0;
    wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) clock_bit(!b[i], 1'b0, tag);
    clock_bit(1'b0, exp_ack, tag);
  endtask

  task automatic read_byte(input logic mack, input string tag);
    logic [7:0] b;
    b = mem_val(model_ptr);
    for (int i = 7; i >= 0; i--) clock_bit(1'b0, !b[i], tag);
    clock_bit(mack, 1'b0, tag);
    model_ptr = (model_ptr + 1) % (1 << AW);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    send_byte(8'hA4, 1'b1, tag);
    send_byte(hi, 1'b1, tag);
    send_byte(lo, 1'b1, tag);
    model_ptr = lo % (1 << AW);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (sda_oe !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: sda_oe_o=%b expected 0", sda_oe);
    end

    // R1 header mismatches: type, fixed zero bit, select bits
    bus_start(); send_byte(8'hB4, 1'b0, "R1 type"); bus_stop();
    bus_start(); send_byte(8'hAC, 1'b0, "R1 fixed zero"); bus_stop();
    bus_start(); send_byte(8'hA2, 1'b0, "R1 select"); bus_stop();

    // R8 traffic ignored after mismatch and after stop
    bus_start(); send_byte(8'hB4, 1'b0, "R1 type");
    send_byte(8'hA5, 1'b0, "R8 after mismatch"); bus_stop();
    send_byte(8'hA5, 1'b0, "R8 no start");

    // R2 R3 set current address then R4 current reads
    bus_start(); set_addr(8'h00, 8'h05, "R3 set addr"); bus_stop();
    bus_start(); send_byte(8'hA5, 1'b1, "R4 header"); read_byte(1'b0, "R4 read 5"); bus_stop();
    bus_start(); send_byte(8'hA5, 1'b1, "R4 header"); read_byte(1'b0, "R4 read 6"); bus_stop();

    // R5 random read, R6 sequential, R7 wrap
    bus_start(); set_addr(8'h00, 8'h1E, "R5 addr");
    bus_start(); send_byte(8'hA5, 1'b1, "R5 header");
    read_byte(1'b1, "R5 read 30");
    read_byte(1'b1, "R6 read 31");
    read_byte(1'b1, "R7 wrap 0");
    read_byte(1'b0, "R6 read 1 nack");
    bus_stop();

    // R2 high byte bits above AW ignored
    bus_start(); set_addr(8'hFF, 8'h03, "R2 addr"); bus_stop();
    bus_start(); send_byte(8'hA5, 1'b1, "R2 header"); read_byte(1'b0, "R2 read 3"); bus_stop();

    // R9 trailing write data not acknowledged, pointer unchanged
    bus_start(); set_addr(8'h00, 8'h09, "R9 addr");
    send_byte(8'h55, 1'b0, "R9 data nack"); bus_stop();
    bus_start(); send_byte(8'hA5, 1'b1, "R9 header"); read_byte(1'b0, "R9 read 9"); bus_stop();

    // R1 other strap value, R11 data pattern
    sel = 2'b01;
    bus_start(); send_byte(8'hA4, 1'b0, "R1 old select");  bus_stop();
    bus_start(); send_byte(8'hA3, 1'b1, "R1 select 01");
    read_byte(1'b1, "R11 read 10"); read_byte(1'b0, "R11 read 11"); bus_stop();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule